// File: doc/BRIEF.md
# MMU Access Check and Fault Status

This block takes a translation entry that a table walk has already fetched and checks it against the access in progress. The inputs are the entry's 3-bit permission code, the kind of access (load, store, instruction fetch or a combined store-fetch), the privilege mode, the entry's modified bit, any fault code the walk produced, and two controls: a no-fault mode and a trap-enable. One cycle later it returns the rights that may be cached for the page, and says whether the access must trap. The trap is reported on an instruction-side or a data-side pulse.

Each recorded fault updates two registers. The status register keeps the access index, the fault code and a valid bit, and it marks an overflow when a second fault arrives before software has read the first. The address register keeps the faulting virtual address. A simple read port returns either register. Reading the status register clears it. Reading the address register has no side effect.

Top module: `mmu_access_check`

## Requirements
- R1: The access index is {write, fetch, supervisor}: bit 2 is set for a store, bit 1 for an instruction fetch and bit 0 for supervisor mode. In the status register it sits at bits [7:5].
- R2: `rsp_rights` is {read, write, execute} (bit 2 = R, bit 1 = W, bit 0 = X). For a supervisor, permission codes 0..7 grant R, RW, RX, RWX, X, RW, RX, RWX. For a user, codes 0..4 grant the same as for a supervisor, and codes 5, 6 and 7 grant R, nothing and nothing.
- R3: While `acc_modified` is 0, the W bit is removed from the granted rights of a non-faulting access.
- R4: The check code is 3 (privilege) for a user access with permission code 6 or 7. Otherwise it is 2 (protection) when a right the access needs is missing from the mode's rights (a plain load needs R, a store needs W, a fetch needs X, a store-fetch needs W and X). Otherwise it is 0.
- R5: When `nofault_mode` is 1 and the access is from user mode, a non-zero check code is neither recorded nor trapped, and the normal rights are returned.
- R6: A non-zero `walk_code` replaces the check code. It is always recorded, even under R5.
- R7: When a fault is recorded and the status register is non-zero, the register becomes 1 before the update. The update ORs in (index << 5), the fault code and the value 2.
- R8: A recorded fault loads `acc_addr` into the address register. Without a fault, the address register keeps its value.
- R9: A recorded fault traps only when `nofault_mode` is 0 and `traps_on` is 1. A trap gives `rsp_fault`=1 and rights 000, with `ifault_pulse` for a fetch or `dfault_pulse` otherwise, for that one response cycle. A fault that does not trap gives rights 111 and no pulse.
- R10: `rd_en` with `rd_sel`=0 reads the status register and `rd_sel`=1 reads the address register. The data appears one cycle later with the value from before that edge. A status read clears the register. If a fault arrives on the same edge, the new status is built as if the old value were 0.
- R11: A response comes one cycle after `acc_valid`. After reset both registers and all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | REG_W | Virtual address of the access |
| acc_perm | input | 3 | Permission code from the entry |
| acc_write | input | 1 | Store access |
| acc_fetch | input | 1 | Instruction fetch access |
| acc_super | input | 1 | Supervisor mode (0 = user) |
| acc_modified | input | 1 | Entry modified bit |
| walk_code | input | WALK_W | Fault code from the walk, 0 if none |
| nofault_mode | input | 1 | No-fault mode control |
| traps_on | input | 1 | Traps enabled |
| rsp_valid | output | 1 | Response valid |
| rsp_rights | output | 3 | Granted {R,W,X} |
| rsp_fault | output | 1 | Access traps |
| ifault_pulse | output | 1 | Instruction fault, one cycle |
| dfault_pulse | output | 1 | Data fault, one cycle |
| rd_en | input | 1 | Register read request |
| rd_sel | input | 1 | 0 = status, 1 = fault address |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | REG_W | Read data |

## Verification
Directed steps come first. They cover a user load on permission codes 6 and 7, which separates the privilege code from the protection code. A supervisor store on a read-execute page and a user fetch on a read-only page are sent back to back, so an overflowing status is told apart from a plain update. A walk fault under no-fault mode shows that walk codes escape the user suppression. A fault on the same edge as a status read shows the read-clear ordering. A random phase then mixes every permission code, access kind, mode, modified bit, the two controls and register reads. In that phase the rights masking and the trap/no-trap split are compared against a model that works out the check code from the needed rights and not from a table.

// File: rtl/mmuchk_pkg.sv
package mmuchk_pkg;

   // granted-rights bit positions
   localparam int RGT_R = 2;
   localparam int RGT_W = 1;
   localparam int RGT_X = 0;

   typedef logic [2:0] rights_t;

   // check codes
   localparam logic [1:0] CHK_OK   = 2'd0;
   localparam logic [1:0] CHK_PROT = 2'd2;
   localparam logic [1:0] CHK_PRIV = 2'd3;

   // rights a mode may hold for a permission code
   function automatic rights_t mode_rights(input logic user, input logic [2:0] perm);
      rights_t r;
      case (perm)
         3'd0: r = 3'b100;
         3'd1: r = 3'b110;
         3'd2: r = 3'b101;
         3'd3: r = 3'b111;
         3'd4: r = 3'b001;
         3'd5: r = user ? 3'b100 : 3'b110;
         3'd6: r = user ? 3'b000 : 3'b101;
         default: r = user ? 3'b000 : 3'b111;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/mmuchk_perm_eval.sv
module mmuchk_perm_eval
   import mmuchk_pkg::*;
#(
   parameter bit USE_ROM = 1'b1
) (
   input  logic [2:0] perm,
   input  logic       is_write,
   input  logic       is_fetch,
   input  logic       is_super,
   output logic [2:0] acc_idx,
   output rights_t    base_rights,
   output logic [1:0] chk_code
);

   assign acc_idx     = {is_write, is_fetch, is_super};
   assign base_rights = mode_rights(!is_super, perm);

   generate
      if (USE_ROM) begin : g_rom
         // row = access index, 2 bits per permission code, code 0 at LSB
         localparam logic [127:0] CODE_ROM = {
            16'h2A2A, 16'hFA2A, 16'h2222, 16'hFA22,
            16'h080A, 16'hF80A, 16'h0200, 16'hF200};
         logic [6:0] bitpos;
         assign bitpos   = {acc_idx, perm, 1'b0};
         assign chk_code = CODE_ROM[bitpos +: 2];
      end else begin : g_logic
         logic    priv_hit;
         rights_t need;
         assign priv_hit = !is_super && perm[2] && perm[1];
         assign need     = {!is_write && !is_fetch, is_write, is_fetch};
         assign chk_code = priv_hit ? CHK_PRIV :
                           (|(need & ~base_rights)) ? CHK_PROT : CHK_OK;
      end
   endgenerate

endmodule

// File: rtl/mmuchk_fault_regs.sv
module mmuchk_fault_regs #(
   parameter int REG_W     = 32,
   parameter int CODE_W    = 10,
   parameter int IDX_SHIFT = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rec_en,
   input  logic [2:0]        rec_idx,
   input  logic [CODE_W-1:0] rec_code,
   input  logic [REG_W-1:0]  rec_addr,
   input  logic              rd_en,
   input  logic              rd_sel,
   output logic              rd_valid,
   output logic [REG_W-1:0]  rd_data
);

   localparam logic [REG_W-1:0] VALID_BIT = REG_W'(2);
   localparam logic [REG_W-1:0] OVF_BIT   = REG_W'(1);

   logic [REG_W-1:0] fsr, far_q, fsr_base, fsr_new;
   logic             fsr_rd;

   assign fsr_rd   = rd_en && !rd_sel;
   assign fsr_base = fsr_rd ? '0 : fsr;
   assign fsr_new  = ((fsr_base != '0) ? OVF_BIT : '0)
                   | (REG_W'(rec_idx) << IDX_SHIFT)
                   | REG_W'(rec_code)
                   | VALID_BIT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsr      <= '0;
         far_q    <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         fsr      <= rec_en ? fsr_new : fsr_base;
         if (rec_en) far_q <= rec_addr;
         rd_valid <= rd_en;
         rd_data  <= rd_en ? (rd_sel ? far_q : fsr) : '0;
      end
   end

   // R7
   fsr_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rec_en |=> fsr[1]);

   // R7
   overflow_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_en && !fsr_rd && fsr != '0) |=> fsr[0]);

   // R10
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fsr_rd && !rec_en) |=> (fsr == '0));

   // R8
   far_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rec_en |=> $stable(far_q));

endmodule

// File: rtl/mmu_access_check.sv
module mmu_access_check
   import mmuchk_pkg::*;
#(
   parameter int REG_W     = 32,
   parameter int WALK_W    = 10,
   parameter int IDX_SHIFT = 5,
   parameter bit USE_ROM   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [REG_W-1:0]  acc_addr,
   input  logic [2:0]        acc_perm,
   input  logic              acc_write,
   input  logic              acc_fetch,
   input  logic              acc_super,
   input  logic              acc_modified,
   input  logic [WALK_W-1:0] walk_code,
   input  logic              nofault_mode,
   input  logic              traps_on,
   output logic              rsp_valid,
   output logic [2:0]        rsp_rights,
   output logic              rsp_fault,
   output logic              ifault_pulse,
   output logic              dfault_pulse,
   input  logic              rd_en,
   input  logic              rd_sel,
   output logic              rd_valid,
   output logic [REG_W-1:0]  rd_data
);

   initial begin
      if (WALK_W < 2)                  $error("WALK_W must hold a check code");
      if (WALK_W > REG_W)              $error("WALK_W wider than REG_W");
      if (IDX_SHIFT + 3 > REG_W)       $error("index field outside REG_W");
   end

   localparam rights_t ALL_RIGHTS = 3'b111;
   localparam rights_t NO_WRITE   = 3'b101;

   logic [2:0]        acc_idx;
   rights_t           base_rights, grant_d;
   logic [1:0]        chk_code;
   logic              walk_hit, tbl_hit, rec_en, trap_d;
   logic [WALK_W-1:0] err_code;

   mmuchk_perm_eval #(.USE_ROM(USE_ROM)) u_eval (
      .perm        (acc_perm),
      .is_write    (acc_write),
      .is_fetch    (acc_fetch),
      .is_super    (acc_super),
      .acc_idx     (acc_idx),
      .base_rights (base_rights),
      .chk_code    (chk_code)
   );

   assign walk_hit = |walk_code;
   assign tbl_hit  = (chk_code != CHK_OK) && !(nofault_mode && !acc_super);
   assign err_code = walk_hit ? walk_code : (tbl_hit ? WALK_W'(chk_code) : '0);
   assign rec_en   = acc_valid && (walk_hit || tbl_hit);
   assign trap_d   = rec_en && !nofault_mode && traps_on;
   assign grant_d  = rec_en ? (trap_d ? '0 : ALL_RIGHTS)
                            : (base_rights & (acc_modified ? ALL_RIGHTS : NO_WRITE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_rights   <= '0;
         rsp_fault    <= 1'b0;
         ifault_pulse <= 1'b0;
         dfault_pulse <= 1'b0;
      end else begin
         rsp_valid    <= acc_valid;
         rsp_rights   <= acc_valid ? grant_d : '0;
         rsp_fault    <= trap_d;
         ifault_pulse <= trap_d && acc_fetch;
         dfault_pulse <= trap_d && !acc_fetch;
      end
   end

   mmuchk_fault_regs #(
      .REG_W     (REG_W),
      .CODE_W    (WALK_W),
      .IDX_SHIFT (IDX_SHIFT)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .rec_en   (rec_en),
      .rec_idx  (acc_idx),
      .rec_code (err_code),
      .rec_addr (acc_addr),
      .rd_en    (rd_en),
      .rd_sel   (rd_sel),
      .rd_valid (rd_valid),
      .rd_data  (rd_data)
   );

   // R9
   side_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ifault_pulse && dfault_pulse));

   // R9
   trap_no_rights_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> (rsp_rights == 3'b000));

   // R3
   clean_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_modified && !nofault_mode && traps_on) |=> !rsp_rights[RGT_W]);

   // R11
   rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> rsp_valid);

endmodule

// File: tb/tb_mmu_access_check.sv
`timescale 1ns/1ps
module tb_mmu_access_check;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 0, acc_write = 0, acc_fetch = 0, acc_super = 0, acc_modified = 0;
   logic [31:0] acc_addr = '0;
   logic [2:0]  acc_perm = '0;
   logic [9:0]  walk_code = '0;
   logic        nofault_mode = 0, traps_on = 0, rd_en = 0, rd_sel = 0;
   logic        rsp_valid, rsp_fault, ifault_pulse, dfault_pulse, rd_valid;
   logic [2:0]  rsp_rights;
   logic [31:0] rd_data;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   logic [31:0] fsr_m = '0, far_m = '0;

   always #4 clk = ~clk;

   mmu_access_check dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_perm(acc_perm), .acc_write(acc_write), .acc_fetch(acc_fetch),
      .acc_super(acc_super), .acc_modified(acc_modified), .walk_code(walk_code),
      .nofault_mode(nofault_mode), .traps_on(traps_on), .rsp_valid(rsp_valid),
      .rsp_rights(rsp_rights), .rsp_fault(rsp_fault), .ifault_pulse(ifault_pulse),
      .dfault_pulse(dfault_pulse), .rd_en(rd_en), .rd_sel(rd_sel),
      .rd_valid(rd_valid), .rd_data(rd_data));

   function automatic logic [2:0] rights_f(input bit user, input logic [2:0] p);
      logic [2:0] sup [8] = '{3'b100, 3'b110, 3'b101, 3'b111, 3'b001, 3'b110, 3'b101, 3'b111};
      if (user && p == 3'd5) return 3'b100;
      if (user && p >= 3'd6) return 3'b000;
      return sup[p];
   endfunction

   function automatic logic [1:0] code_f(input bit w, input bit f, input bit s, input logic [2:0] p);
      logic [2:0] need;
      if (!s && p >= 3'd6) return 2'd3;
      need = {!w && !f, w, f};
      return ((need & ~rights_f(!s, p)) != 0) ? 2'd2 : 2'd0;
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic step(input bit v, input logic [31:0] a, input logic [2:0] p,
                       input bit w, input bit f, input bit s, input bit m,
                       input logic [9:0] wc, input bit nf, input bit tr,
                       input bit rd, input bit sel, input string tag);
      logic [31:0] base, exp_rd, err;
      logic [2:0]  exp_r, idx;
      logic [1:0]  ct;
      bit          exp_fault, exp_if, exp_df;
      string       t;
      acc_valid = v; acc_addr = a; acc_perm = p; acc_write = w; acc_fetch = f;
      acc_super = s; acc_modified = m; walk_code = wc; nofault_mode = nf;
      traps_on = tr; rd_en = rd; rd_sel = sel;
      idx = {w, f, s};
      ct  = code_f(w, f, s, p);
      err = (wc != 0) ? 32'(wc) : ((ct != 0 && !(nf && !s)) ? 32'(ct) : 32'd0);
      exp_rd = sel ? far_m : fsr_m;
      base = (rd && !sel) ? 32'd0 : fsr_m;
      exp_fault = 0; exp_if = 0; exp_df = 0;
      t = tag;
      if (v && err != 0) begin
         fsr_m = ((base != 0) ? 32'd1 : 32'd0) | (32'(idx) << 5) | err | 32'd2;
         far_m = a;
         if (!nf && tr) begin
            exp_r = 3'b000; exp_fault = 1; exp_if = f; exp_df = !f;
         end else exp_r = 3'b111;
         if (t == "") t = "R9";
      end else begin
         fsr_m = base;
         exp_r = rights_f(!s, p) & (m ? 3'b111 : 3'b101);
         if (t == "") t = (ct != 0) ? "R5" : (!m ? "R3" : "R2");
      end
      @(posedge clk);
      @(negedge clk);
      chk(t, "rsp_valid", 32'(rsp_valid), 32'(v));
      if (v) chk(t, "rsp_rights", 32'(rsp_rights), 32'(exp_r));
      chk(t, "rsp_fault", 32'(rsp_fault), 32'(exp_fault));
      chk(t, "ifault_pulse", 32'(ifault_pulse), 32'(exp_if));
      chk(t, "dfault_pulse", 32'(dfault_pulse), 32'(exp_df));
      chk(t, "rd_valid", 32'(rd_valid), 32'(rd));
      if (rd) chk(tag == "" ? "R10" : tag, "rd_data", rd_data, exp_rd);
   endtask

   task automatic rdreg(input bit sel, input string tag);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, sel, tag);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk("R11", "rsp_valid in reset", 32'(rsp_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11", "rd_valid after reset", 32'(rd_valid), 0);
      rdreg(0, "R11");
      rdreg(1, "R11");
      // user load, permission 6: privilege code
      step(1, 32'h1000_0040, 3'd6, 0, 0, 0, 1, 0, 0, 1, 0, 0, "R4");
      rdreg(0, "R4");
      rdreg(0, "R10");
      // supervisor store on RX page, then user fetch on R page: overflow
      step(1, 32'h2000_1000, 3'd6, 1, 0, 1, 1, 0, 0, 1, 0, 0, "R1");
      step(1, 32'h3000_2000, 3'd0, 0, 1, 0, 1, 0, 0, 1, 0, 0, "R9");
      rdreg(0, "R7");
      rdreg(1, "R8");
      // no-fault user suppression
      step(1, 32'h4000_0000, 3'd7, 0, 0, 0, 1, 0, 1, 1, 0, 0, "R5");
      rdreg(0, "R5");
      rdreg(1, "R8");
      // walk fault under no-fault mode
      step(1, 32'h5000_0010, 3'd3, 0, 0, 0, 1, 10'h104, 1, 1, 0, 0, "R6");
      rdreg(0, "R6");
      // modified masking
      step(1, 32'h6000_0000, 3'd1, 1, 0, 1, 0, 0, 0, 1, 0, 0, "R3");
      step(1, 32'h6000_0000, 3'd1, 1, 0, 1, 1, 0, 0, 1, 0, 0, "R2");
      step(1, 32'h6000_0000, 3'd5, 0, 0, 0, 1, 0, 0, 1, 0, 0, "R2");
      // traps off
      step(1, 32'h7000_0000, 3'd0, 1, 0, 1, 1, 0, 0, 0, 0, 0, "R9");
      // fault on the edge of a status read
      step(1, 32'h8000_0000, 3'd4, 0, 0, 1, 1, 0, 0, 1, 1, 0, "R10");
      rdreg(0, "R10");
      for (int i = 0; i < 4000; i++) begin
         logic [9:0] wc;
         wc = ($urandom_range(7) == 0) ? 10'($urandom_range(1023)) : 10'd0;
         step($urandom_range(3) != 0, $urandom, 3'($urandom_range(7)),
              1'($urandom_range(1)), 1'($urandom_range(1)), 1'($urandom_range(1)),
              1'($urandom_range(1)), wc, $urandom_range(3) == 0,
              $urandom_range(3) != 0, $urandom_range(2) == 0,
              1'($urandom_range(1)), "");
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule